// File: doc/BRIEF.md
# Clocked Serial Transfer Unit

This block is a synchronous serial shifter with a small register port. Software loads one or two data bytes and sets a start bit. The unit then shifts the bits out least-significant first on a serial output. At the same time it shifts incoming bits from a serial input into the same registers. At the end of the transfer the registers hold the received data.

A transfer is 8 bits long (lower data register only) or 16 bits long (upper and lower registers chained into one shift path). The serial clock comes from one of two sources:
- an internal divider, which also drives the clock output pin;
- an external clock pin, which is synchronized with two flops before its edges are detected.

The start bit stays set for the whole transfer, including the time spent waiting for the first external clock edge, so software can use it as a busy flag. A one-cycle done pulse marks the end of each transfer.

Top module: `sst_unit`

## Requirements
- R1: When the unit is idle, a write to address 0 with bit 0 set starts a transfer and the busy flag rises on the next cycle. A write with bit 0 clear starts nothing.
- R2: Reading address 0 returns the busy flag in bit 0. It stays 1 from the start write until completion, including the time spent waiting for the first external clock edge.
- R3: When the last bit has been received, the busy flag clears and `done` is high for exactly one cycle. There is one such pulse per transfer.
- R4: The control layout is: bit 0 start/busy, bit 1 reserved, bit 5 length select (1 = 16 bits), bit 6 clock source (1 = external). Bit 1 stores and reads back the value written and has no effect. Bits 7 and 4..2 always read 0.
- R5: A control write that arrives while busy has no effect, including one that arrives in the same cycle as the final clock edge. Length and clock source keep their values, and no second transfer starts.
- R6: In an 8-bit transfer, the lower register (address 1) is sent on `so` least-significant bit first. `so` changes only at falling serial clock edges.
- R7: In a 16-bit transfer, the 8 bits of the lower register go out first, followed by the 8 bits of the upper register (address 2), each least-significant bit first.
- R8: `si` is sampled on each rising serial clock edge and enters at the top of the chain. After an 8-bit transfer, the lower register holds the received byte, with the first bit in bit 0. After a 16-bit transfer, {upper, lower} holds the 16 bits, with the first bit in bit 0.
- R9: With the internal clock, `sck_out` is high while idle and toggles every DIV system cycles during a transfer. A transfer has 8 or 16 low phases, each DIV cycles long.
- R10: With the external clock, `sck_out` stays high. Rising edges of `sck_in` count only after the first falling edge seen since the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 2 | register select: 0 control, 1 lower data, 2 upper data |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for `addr`, combinational |
| sck_in | input | 1 | external serial clock |
| sck_out | output | 1 | internal serial clock output, idle high |
| si | input | 1 | serial data input |
| so | output | 1 | serial data output |
| done | output | 1 | one-cycle completion pulse |

## Verification
Two events can fall in the same system cycle: the final rising serial edge, which ends the transfer, and a software control write that tries to start a new transfer with a different length and clock source. With the external clock, the bench knows exactly when the synchronized edge is registered. It places the write in that cycle. It then checks three things: `done` pulses once, the busy flag reads 0, and the control read-back still shows the old mode, so the write was ignored.

// File: rtl/sst_unit.sv
module sst_unit #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sck_in,
  output logic       sck_out,
  input  logic       si,
  output logic       so,
  output logic       done
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  logic           busy, rsv, len16, ext;
  logic [7:0]     lo, hi;
  logic           sck_q, so_q, done_q;
  logic [DCW-1:0] dcnt;
  logic [4:0]     bcnt;
  logic           s1, s2, s3, seen;

  logic ctrl_wr, start, tick, fall, rise, last;

  assign ctrl_wr = wr_en && addr == 2'd0 && !busy;
  assign start   = ctrl_wr && wdata[0];
  assign tick    = busy && !ext && dcnt == DCW'(DIV - 1);
  assign fall    = ext ? (busy && s3 && !s2) : (tick && sck_q);
  assign rise    = ext ? (busy && seen && !s3 && s2) : (tick && !sck_q);
  assign last    = bcnt == (len16 ? 5'd15 : 5'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sck_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rsv    <= 1'b0;
      len16  <= 1'b0;
      ext    <= 1'b0;
      sck_q  <= 1'b1;
      so_q   <= 1'b1;
      done_q <= 1'b0;
      dcnt   <= '0;
      bcnt   <= '0;
      seen   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ctrl_wr) begin
        rsv   <= wdata[1];
        len16 <= wdata[5];
        ext   <= wdata[6];
      end
      if (start) begin
        busy  <= 1'b1;
        sck_q <= 1'b1;
        dcnt  <= '0;
        bcnt  <= '0;
        seen  <= 1'b0;
      end else if (busy) begin
        if (!ext) dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) sck_q <= ~sck_q;
        if (fall) begin
          so_q <= lo[0];
          seen <= 1'b1;
        end
        if (rise) begin
          bcnt <= bcnt + 1'b1;
          if (last) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr == 2'd1) lo <= wdata;
    if (wr_en && addr == 2'd2) hi <= wdata;
    if (rise) begin
      if (len16) begin
        hi <= {si, hi[7:1]};
        lo <= {hi[0], lo[7:1]};
      end else begin
        lo <= {si, lo[7:1]};
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, ext, len16, 3'b000, rsv, busy};
      2'd1:    rdata = lo;
      2'd2:    rdata = hi;
      default: rdata = 8'h00;
    endcase
  end

  assign sck_out = sck_q;
  assign so      = so_q;
  assign done    = done_q;
endmodule

// File: rtl/sst_unit_chk.sv
module sst_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       sck_out,
  input logic       done,
  input logic       busy
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && wdata[0] && !busy |=> busy); // R1
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && !wdata[0] && !busy |=> !busy); // R1
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[0] == busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_CTRL_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[4:2] == 3'b000 && !rdata[7]); // R4
  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rdata[6:5]) || addr != 2'd0 || $past(addr) != 2'd0); // R5
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out); // R9
endmodule

bind sst_unit sst_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .sck_out(sck_out), .done(done), .busy(busy)
);

// File: tb/sst_unit_test.sv
module sst_unit_test;
  localparam int DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sck_in = 1'b1, si = 1'b0;
  logic       sck_out, so, done;

  int checks = 0, fails = 0, dones = 0;
  bit finished = 0;

  sst_unit #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sck_in(sck_in), .sck_out(sck_out), .si(si), .so(so),
    .done(done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && done) dones++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] ctrl_word(input bit l16, input bit ex, input bit st);
    return {1'b0, ex, l16, 3'b000, 1'b0, st};
  endfunction

  function automatic logic [15:0] expect_rx(input bit l16, input logic [15:0] sin,
                                            input logic [15:0] data);
    return l16 ? sin : {data[15:8], sin[7:0]};
  endfunction

  task automatic xfer(input bit l16, input bit ex, input logic [15:0] data,
                      input logic [15:0] sin, input bit collide);
    int n = l16 ? 16 : 8;
    logic [15:0] got = '0;
    logic [7:0] r, rl, rh;
    int d0 = dones;
    wr(2'd1, data[7:0]);
    wr(2'd2, data[15:8]);
    wr(2'd0, ctrl_word(l16, ex, 1'b1));
    rd(2'd0, r);
    chk(r[0] == 1'b1, "R1", "busy after start", r[0], 1);
    if (ex) begin
      repeat (10) @(negedge clk);
      rd(2'd0, r);
      chk(r[0] == 1'b1 && dones == d0, "R2", "busy while waiting for edge", r, 1);
      chk(sck_out == 1'b1, "R10", "sck_out held high", sck_out, 1);
      wr(2'd0, ctrl_word(!l16, 1'b0, 1'b1));
      rd(2'd0, r);
      chk(r == ctrl_word(l16, 1'b1, 1'b1), "R5", "ctrl write while busy", r,
          ctrl_word(l16, 1'b1, 1'b1));
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        sck_in = 1'b0; si = sin[i];
        repeat (4) @(negedge clk);
        got[i] = so;
        sck_in = 1'b1;
        if (collide && i == n - 1) begin
          @(negedge clk);
          @(negedge clk);
          wr_en = 1'b1; addr = 2'd0; wdata = ctrl_word(!l16, 1'b0, 1'b1);
          @(negedge clk);
          wr_en = 1'b0;
          chk(done == 1'b1, "R3", "done in collision cycle", done, 1);
          rd(2'd0, r);
          chk(r == ctrl_word(l16, 1'b1, 1'b0), "R5", "start in final-edge cycle ignored",
              r, ctrl_word(l16, 1'b1, 1'b0));
        end else begin
          repeat (3) @(negedge clk);
        end
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        int g = 0, low = 0;
        bit p = sck_out;
        while (!(p && !sck_out) && g < 100) begin p = sck_out; @(negedge clk); g++; end
        si = sin[i];
        while (!sck_out && low < 100) begin @(negedge clk); low++; end
        got[i] = so;
        if (i == 0 || i == n - 1)
          chk(low == DIV, "R9", "low phase length", low, DIV);
      end
    end
    repeat (4) @(negedge clk);
    rd(2'd0, r);
    chk(r[0] == 1'b0, "R3", "busy cleared", r[0], 0);
    chk(dones == d0 + 1, "R3", "one done pulse", dones - d0, 1);
    chk(sck_out == 1'b1, "R9", "sck_out idle high", sck_out, 1);
    if (l16)
      chk(got == data, "R7", "16-bit serial output", got, data);
    else
      chk(got[7:0] == data[7:0], "R6", "8-bit serial output", got[7:0], data[7:0]);
    rd(2'd1, rl);
    rd(2'd2, rh);
    chk({rh, rl} == expect_rx(l16, sin, data), "R8", "received data", {rh, rl},
        expect_rx(l16, sin, data));
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r);
    chk(r == 8'h00, "R4", "ctrl after reset", r, 0);
    chk(sck_out == 1'b1 && done == 1'b0, "R9", "idle outputs after reset",
        {sck_out, done}, 2'b10);
    wr(2'd0, 8'h9E);
    rd(2'd0, r);
    chk(r == 8'h02, "R4", "reserved/unused bits", r, 8'h02);
    wr(2'd0, 8'h20);
    repeat (5) @(negedge clk);
    rd(2'd0, r);
    chk(r == 8'h20 && sck_out == 1'b1, "R1", "start bit 0 starts nothing", r, 8'h20);
    xfer(1'b0, 1'b0, 16'h00A5, 16'h003C, 1'b0);
    xfer(1'b1, 1'b0, 16'h8001, 16'hFFFF, 1'b0);
    xfer(1'b0, 1'b1, 16'h0000, 16'h00FF, 1'b0);
    xfer(1'b1, 1'b1, 16'h1234, 16'hBEEF, 1'b1);
    for (int k = 0; k < 24; k++) begin
      logic [31:0] v = $urandom;
      xfer(v[0], v[1], 16'($urandom), 16'($urandom), v[2] & v[1]);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule